// File: doc/BRIEF.md
# Compare-Mode Receive Image Buffer

This block is a receive buffer that does not keep what it receives. It checks it instead. The test side first loads a dual-ported RAM with the expected data image, one 32-bit word per address, and programs how many words the image holds. While compare mode is on, each word that arrives from the peripheral side is checked against the image word at the current read pointer, and the pointer then moves to the next word.

Two sticky flags tell the test side what happened. One flag says that some word differed from the image, and the index of the first such word is kept with it. The other flag says that the whole image has been consumed. The test side can also place the read pointer anywhere, which lets a compare start in the middle of an image or be run again. Both sides share one clock.

Top module: `cmpRxBuf`

## Requirements
- R1: A cycle with `imgWrEn` high stores `imgWrData` as image word `imgWrAddr`. Later compares at that index use this value.
- R2: While `cmpModeEn` is 1, a cycle with `rxValid` high and `rdPtr` below the image length compares `rxData` with image word `rdPtr`. `rdPtr` increases by one in the following cycle.
- R3: While `cmpModeEn` is 0, `rxValid` and `rxData` change neither `rdPtr` nor either flag.
- R4: A compared word that differs from its image word in any bit sets `mismatchFlag` in the next cycle. A word that matches leaves `mismatchFlag` as it was.
- R5: `firstBadIdx` loads the low address bits of `rdPtr` for a differing word only when `mismatchFlag` is 0 in that cycle. Otherwise it keeps its value.
- R6: `doneFlag` sets in the cycle after the compare that brings `rdPtr` up to the image length.
- R7: While `rdPtr` is at or beyond the image length, incoming words are ignored. The pointer stays put and neither flag is set by them.
- R8: The flags are sticky. Bit 0 of `clrMask` clears `mismatchFlag` and bit 1 clears `doneFlag`, one cycle after the write. A set in the same cycle wins over the clear.
- R9: `ptrWrEn` loads `rdPtr` from `ptrWrData` and takes priority over an advance in the same cycle. `lenWrEn` loads the image length from `lenWrData`. Lengths above the RAM depth are not supported.
- R10: After reset, `rdPtr`, the image length, `firstBadIdx` and both flags are 0.
- R11: With an image length of 0, no incoming word is compared, and `doneFlag` is not set by incoming words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rstN | input | 1 | Active-low synchronous reset |
| imgWrEn | input | 1 | Write one image word |
| imgWrAddr | input | ADDR_W | Image word index to write |
| imgWrData | input | DATA_W | Image word value |
| lenWrEn | input | 1 | Load the image length |
| lenWrData | input | ADDR_W+1 | New image length in words |
| ptrWrEn | input | 1 | Load the read pointer |
| ptrWrData | input | ADDR_W+1 | New read pointer value |
| clrMask | input | 2 | Write-one-to-clear: bit 0 mismatch, bit 1 done |
| cmpModeEn | input | 1 | Receive mode is compare |
| rxValid | input | 1 | Incoming word present |
| rxData | input | DATA_W | Incoming word |
| mismatchFlag | output | 1 | Sticky: some word differed from the image |
| doneFlag | output | 1 | Sticky: image fully consumed |
| firstBadIdx | output | ADDR_W | Index of the first differing word |
| rdPtr | output | ADDR_W+1 | Current read pointer |

## Verification
Every result is due exactly one clock after the cycle that caused it. This holds for the pointer step, a flag set or clear, the index capture and a pointer or length load. An image write is seen by the first compare after its edge. The bench sets inputs just after a rising edge, then advances its own model across the next edge from the same inputs, and samples the outputs shortly after that edge. Every check therefore compares a settled output with the model one register stage later. Directed phases cover mode off, the first and later mismatches, completion, words after completion, set against clear, pointer loads and a zero length. Seeded random cycles then mix all inputs.

// File: rtl/cmp_rx_pkg.sv
package cmp_rx_pkg;
  typedef struct packed {
    logic advance;
    logic loadPtr;
    logic loadLen;
    logic setMis;
    logic setDone;
    logic captureIdx;
  } rxStrobe_t;
endpackage

// File: rtl/cmpRxData.sv
module cmpRxData
  import cmp_rx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic              imgWrEn,
  input  logic [ADDR_W-1:0] imgWrAddr,
  input  logic [DATA_W-1:0] imgWrData,
  input  logic [ADDR_W:0]   ptrWrData,
  input  logic [ADDR_W:0]   lenWrData,
  input  logic [DATA_W-1:0] rxData,
  output logic              atEnd,
  output logic              wordNeq,
  output logic              lastWord,
  output logic [ADDR_W:0]   rdPtr,
  output logic [ADDR_W-1:0] firstBadIdx
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;

  logic [DATA_W-1:0] imgMem [DEPTH];
  logic [PTR_W-1:0]  imgLen;

  always_ff @(posedge clk) begin
    if (imgWrEn) imgMem[imgWrAddr] <= imgWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr       <= '0;
      imgLen      <= '0;
      firstBadIdx <= '0;
    end else begin
      if (strb.loadPtr)      rdPtr <= ptrWrData;
      else if (strb.advance) rdPtr <= rdPtr + PTR_W'(1);
      if (strb.loadLen)      imgLen <= lenWrData;
      if (strb.captureIdx)   firstBadIdx <= rdPtr[ADDR_W-1:0];
    end
  end

  assign atEnd    = rdPtr >= imgLen;
  assign wordNeq  = imgMem[rdPtr[ADDR_W-1:0]] != rxData;
  assign lastWord = (rdPtr + PTR_W'(1)) == imgLen;

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.loadPtr) |=> rdPtr == $past(rdPtr) + PTR_W'(1));

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (atEnd && !strb.loadPtr) |=> $stable(rdPtr));

  // R9
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPtr |=> rdPtr == $past(ptrWrData));
endmodule

// File: rtl/cmpRxCtrl.sv
module cmpRxCtrl
  import cmp_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmpModeEn,
  input  logic       rxValid,
  input  logic       ptrWrEn,
  input  logic       lenWrEn,
  input  logic [1:0] clrMask,
  input  logic       atEnd,
  input  logic       wordNeq,
  input  logic       lastWord,
  output rxStrobe_t  strb,
  output logic       mismatchFlag,
  output logic       doneFlag
);
  logic accept;

  assign accept = cmpModeEn && rxValid && !ptrWrEn && !atEnd;

  always_comb begin
    strb            = '0;
    strb.advance    = accept;
    strb.loadPtr    = ptrWrEn;
    strb.loadLen    = lenWrEn;
    strb.setMis     = accept && wordNeq;
    strb.setDone    = accept && lastWord;
    strb.captureIdx = accept && wordNeq && !mismatchFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mismatchFlag <= 1'b0;
      doneFlag     <= 1'b0;
    end else begin
      mismatchFlag <= strb.setMis  || (mismatchFlag && !clrMask[0]);
      doneFlag     <= strb.setDone || (doneFlag && !clrMask[1]);
    end
  end

  // R4
  mis_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpModeEn && rxValid && !ptrWrEn && !atEnd && wordNeq) |=> mismatchFlag);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !clrMask[1]) |=> doneFlag);

  // R3
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmpModeEn && !mismatchFlag) |=> !mismatchFlag);
endmodule

// File: rtl/cmpRxBuf.sv
module cmpRxBuf
  import cmp_rx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              imgWrEn,
  input  logic [ADDR_W-1:0] imgWrAddr,
  input  logic [DATA_W-1:0] imgWrData,
  input  logic              lenWrEn,
  input  logic [ADDR_W:0]   lenWrData,
  input  logic              ptrWrEn,
  input  logic [ADDR_W:0]   ptrWrData,
  input  logic [1:0]        clrMask,
  input  logic              cmpModeEn,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              mismatchFlag,
  output logic              doneFlag,
  output logic [ADDR_W-1:0] firstBadIdx,
  output logic [ADDR_W:0]   rdPtr
);
  rxStrobe_t strb;
  logic      atEnd;
  logic      wordNeq;
  logic      lastWord;

  cmpRxCtrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmpModeEn    (cmpModeEn),
    .rxValid      (rxValid),
    .ptrWrEn      (ptrWrEn),
    .lenWrEn      (lenWrEn),
    .clrMask      (clrMask),
    .atEnd        (atEnd),
    .wordNeq      (wordNeq),
    .lastWord     (lastWord),
    .strb         (strb),
    .mismatchFlag (mismatchFlag),
    .doneFlag     (doneFlag)
  );

  cmpRxData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .imgWrEn     (imgWrEn),
    .imgWrAddr   (imgWrAddr),
    .imgWrData   (imgWrData),
    .ptrWrData   (ptrWrData),
    .lenWrData   (lenWrData),
    .rxData      (rxData),
    .atEnd       (atEnd),
    .wordNeq     (wordNeq),
    .lastWord    (lastWord),
    .rdPtr       (rdPtr),
    .firstBadIdx (firstBadIdx)
  );

  // R5
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mismatchFlag && !clrMask[0]) |=> $stable(firstBadIdx));

  // R10
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (rdPtr == '0 && !mismatchFlag && !doneFlag && firstBadIdx == '0));
endmodule

// File: tb/test_cmpRxBuf.sv
`timescale 1ns/1ps
module test_cmpRxBuf;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          imgWrEn = 1'b0;
  logic [AW-1:0] imgWrAddr = '0;
  logic [DW-1:0] imgWrData = '0;
  logic          lenWrEn = 1'b0;
  logic [AW:0]   lenWrData = '0;
  logic          ptrWrEn = 1'b0;
  logic [AW:0]   ptrWrData = '0;
  logic [1:0]    clrMask = '0;
  logic          cmpModeEn = 1'b0;
  logic          rxValid = 1'b0;
  logic [DW-1:0] rxData = '0;
  logic          mismatchFlag, doneFlag;
  logic [AW-1:0] firstBadIdx;
  logic [AW:0]   rdPtr;

  cmpRxBuf #(.ADDR_W(AW), .DATA_W(DW)) i_cmpRxBuf (
    .clk(clk), .rstN(rstN), .imgWrEn(imgWrEn), .imgWrAddr(imgWrAddr),
    .imgWrData(imgWrData), .lenWrEn(lenWrEn), .lenWrData(lenWrData),
    .ptrWrEn(ptrWrEn), .ptrWrData(ptrWrData), .clrMask(clrMask),
    .cmpModeEn(cmpModeEn), .rxValid(rxValid), .rxData(rxData),
    .mismatchFlag(mismatchFlag), .doneFlag(doneFlag),
    .firstBadIdx(firstBadIdx), .rdPtr(rdPtr)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DW-1:0] mMem [DEPTH];
  logic [AW:0]   mPtr = '0;
  logic [AW:0]   mLen = '0;
  logic          mMis = 1'b0;
  logic          mDone = 1'b0;
  logic [AW-1:0] mIdx = '0;
  string         tag = "R10";

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll();
    check(tag, "rdPtr", int'(rdPtr), int'(mPtr));
    check(tag, "mismatchFlag", int'(mismatchFlag), int'(mMis));
    check(tag, "doneFlag", int'(doneFlag), int'(mDone));
    check(tag, "firstBadIdx", int'(firstBadIdx), int'(mIdx));
  endtask

  function automatic logic [AW:0] nextPtr(logic acc);
    if (ptrWrEn) return ptrWrData;
    if (acc) return mPtr + 1'b1;
    return mPtr;
  endfunction

  // One clock: model advances from the same inputs the design sees.
  task automatic tick();
    logic acc, neq, setMis, setDone;
    acc = cmpModeEn && rxValid && !ptrWrEn && (mPtr < mLen);
    neq = mMem[mPtr[AW-1:0]] != rxData;
    setMis = acc && neq;
    setDone = acc && ((mPtr + 1'b1) == mLen);
    @(posedge clk);
    #2;
    if (setMis && !mMis) mIdx = mPtr[AW-1:0];
    mMis  = setMis || (mMis && !clrMask[0]);
    mDone = setDone || (mDone && !clrMask[1]);
    mPtr  = nextPtr(acc);
    if (lenWrEn) mLen = lenWrData;
    if (imgWrEn) mMem[imgWrAddr] = imgWrData;
    checkAll();
    imgWrEn = 0; lenWrEn = 0; ptrWrEn = 0; clrMask = '0; rxValid = 0;
  endtask

  task automatic sendWord(logic [DW-1:0] d);
    rxValid = 1; rxData = d; tick();
  endtask

  task automatic setPtr(int v);
    ptrWrEn = 1; ptrWrData = (AW+1)'(v); tick();
  endtask

  task automatic setLen(int v);
    lenWrEn = 1; lenWrData = (AW+1)'(v); tick();
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    for (int i = 0; i < DEPTH; i++) mMem[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    // R10: reset values
    tag = "R10";
    check("R10", "rdPtr reset", int'(rdPtr), 0);
    check("R10", "mismatchFlag reset", int'(mismatchFlag), 0);
    check("R10", "doneFlag reset", int'(doneFlag), 0);
    check("R10", "firstBadIdx reset", int'(firstBadIdx), 0);
    rstN = 1;

    // R1: preload image
    tag = "R1";
    for (int i = 0; i < DEPTH; i++) begin
      imgWrEn = 1; imgWrAddr = AW'(i); imgWrData = 32'hA5000000 + i * 32'h01010101;
      tick();
    end
    tag = "R9";
    setLen(8);

    // R3: mode off ignores words
    tag = "R3";
    cmpModeEn = 0;
    sendWord(32'hDEAD_BEEF);
    sendWord(32'h0);
    check("R3", "rdPtr unchanged with mode off", int'(rdPtr), 0);

    // R2 / R1: matching words advance pointer without mismatch
    tag = "R2";
    cmpModeEn = 1;
    for (int i = 0; i < 3; i++) sendWord(mMem[i]);
    check("R2", "rdPtr after three words", int'(rdPtr), 3);
    check("R1", "no mismatch for stored image", int'(mismatchFlag), 0);

    // R4 / R5: first and second mismatch
    tag = "R4";
    sendWord(mMem[3] ^ 32'h0000_0100);
    check("R4", "single-bit mismatch sets flag", int'(mismatchFlag), 1);
    check("R5", "first index captured", int'(firstBadIdx), 3);
    tag = "R5";
    sendWord(mMem[4]);
    sendWord(~mMem[5]);
    check("R5", "index held on later mismatch", int'(firstBadIdx), 3);

    // R6: completion
    tag = "R6";
    sendWord(mMem[6]);
    check("R6", "not done before last word", int'(doneFlag), 0);
    sendWord(mMem[7]);
    check("R6", "done after last word", int'(doneFlag), 1);

    // R7: words after completion ignored
    tag = "R7";
    clrMask = 2'b01; tick();
    sendWord(32'h1234_5678);
    check("R7", "pointer holds at end", int'(rdPtr), 8);
    check("R7", "no mismatch after end", int'(mismatchFlag), 0);

    // R8: set beats clear, then plain clear
    tag = "R8";
    setPtr(7);
    clrMask = 2'b11; rxValid = 1; rxData = ~mMem[7]; tick();
    check("R8", "done set wins over clear", int'(doneFlag), 1);
    check("R8", "mismatch set wins over clear", int'(mismatchFlag), 1);
    clrMask = 2'b10; tick();
    check("R8", "done cleared", int'(doneFlag), 0);

    // R9: pointer load beats advance
    tag = "R9";
    setPtr(2);
    ptrWrEn = 1; ptrWrData = 7'd5; rxValid = 1; rxData = mMem[2]; tick();
    check("R9", "pointer load wins", int'(rdPtr), 5);

    // R11: zero length
    tag = "R11";
    setLen(0);
    setPtr(0);
    clrMask = 2'b11; tick();
    sendWord(32'hFFFF_FFFF);
    sendWord(mMem[0]);
    check("R11", "zero length compares nothing", int'(rdPtr), 0);
    check("R11", "zero length no done", int'(doneFlag), 0);

    // Random mix
    tag = "R2";
    setLen(16);
    setPtr(0);
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom % 100);
      cmpModeEn = ($urandom % 10) != 0;
      rxValid = ($urandom % 10) < 6;
      rxData = (($urandom % 4) != 0) ? mMem[mPtr[AW-1:0]] : $urandom;
      if (r < 8) begin
        imgWrEn = 1; imgWrAddr = AW'($urandom); imgWrData = $urandom;
      end
      if (r >= 90 && r < 93) begin
        lenWrEn = 1; lenWrData = (AW+1)'($urandom % (DEPTH + 1));
      end
      if (r >= 93 && r < 96) begin
        ptrWrEn = 1; ptrWrData = (AW+1)'($urandom % (DEPTH + 1));
      end
      if (r >= 96) clrMask = 2'($urandom);
      tick();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule